// File: doc/BRIEF.md
# Periodic Interrupt Rate Divider

This block derives the periodic tick of a real-time clock from a one-cycle enable strobe that pulses at 32.768 kHz in the system clock domain. A 4-bit rate code picks the tick period as a power of two number of strobes. Each tick raises a single-cycle flag for the interrupt status logic, and, when square-wave output is enabled, a single-cycle pulse on a separate output.

Ticks do not count from the moment the divider is enabled. A free-running 16-bit strobe counter runs from reset, and ticks fall on the multiples of the period in that count. When software changes the rate code or the enables, it raises a configuration write strobe; in the following cycle the block finds the first period multiple strictly above the current count and takes that as its next tick point.

Top module: `prd_rate_divider`

## Requirements
- R1: After reset `pf_set` and `sqw_pulse` are low and the strobe counter is zero, so with rate code 3 set up before any strobe the first tick follows the 4th strobe.
- R2: Rate code 0 produces no ticks, whatever the enable inputs.
- R3: For rate codes 3 to 15 the tick period is 2^(code-1) strobes (code 3: 4 strobes, code 15: 16384 strobes).
- R4: Rate codes 1 and 2 are raised by seven before use: code 1 gives a period of 128 strobes and code 2 a period of 256 strobes.
- R5: The divider ticks only when `pie_en` is high, or when `sqw_en` is high and the square-wave output is built in (`HAS_SQW` = 1); with both enables low it produces no ticks.
- R6: Every tick falls on a strobe that brings the free-running strobe count (number of strobes since reset, modulo 2^CNT_W) to a multiple of the period.
- R7: `pf_set` pulses on every tick even when `pie_en` is low, as long as the divider runs through the square-wave enable.
- R8: With `sqw_en` high, `sqw_pulse` is a one-cycle pulse in the same cycle as `pf_set` on each tick; with `sqw_en` low it stays low.
- R9: A cycle with `cfg_wr` high makes the block, in the next cycle, take as its next tick point the first period multiple strictly above the current count, so the first tick comes after P - (count mod P) strobes.
- R10: `pf_set` is a one-cycle pulse, high in the cycle right after the clock edge that takes the strobe completing a period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_32k | input | 1 | One-cycle strobe at 32.768 kHz |
| rate_sel | input | 4 | Rate code; 0 disables the tick |
| pie_en | input | 1 | Periodic interrupt enable |
| sqw_en | input | 1 | Square-wave pulse enable |
| cfg_wr | input | 1 | High for one cycle when rate code or enables are written |
| pf_set | output | 1 | One-cycle periodic flag set pulse per tick |
| sqw_pulse | output | 1 | One-cycle square-wave pulse per tick |

## Verification
The bench builds the block with its defaults, a 16-bit strobe counter and the square-wave output present, so the square-wave enable alone can start the divider. With a strobe every second clock, even the slowest code (16384 strobes) runs through two full periods inside the run, and the fast and aliased codes are checked for count and alignment across many ticks. A realignment test places the counter off a period boundary before a configuration write to show that the first tick lands on the next multiple and not one period after the write.

// File: rtl/prd_pkg.sv
// Shared helpers for the periodic rate divider.
// Assumes a 4-bit rate code; the shift it returns never exceeds 14.
package prd_pkg;
    localparam int RATE_W = 4;
    localparam int SHIFT_W = 4;

    // Map a nonzero rate code to log2 of its period in strobes.
    function automatic logic [SHIFT_W-1:0] rate_shift(input logic [RATE_W-1:0] code);
        logic [RATE_W-1:0] eff;
        eff = (code <= 4'd2) ? code + 4'd7 : code;
        return eff - 4'd1;
    endfunction
endpackage

// File: rtl/prd_rate_decode.sv
// Rate code decoder: turns the rate code into an active flag, a period
// and an alignment mask. Purely combinational.
// Assumes CNT_W is wide enough to hold the longest period (2^14).
module prd_rate_decode
    import prd_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic [RATE_W-1:0] code,
    output logic              active,
    output logic [CNT_W-1:0]  period,
    output logic [CNT_W-1:0]  mask
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    // Decode the code into period and boundary mask.
    always_comb begin
        active = (code != '0);
        period = ONE << rate_shift(code);
        mask   = ~(period - ONE);
    end
endmodule

// File: rtl/prd_free_counter.sv
// Free-running strobe counter. Counts every strobe from reset and wraps
// at 2^CNT_W. Exposes the value it takes at the coming edge.
module prd_free_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] cnt_next
);
    // Value after the coming edge.
    always_comb cnt_next = cnt + {{(CNT_W-1){1'b0}}, step};

    // Hold the running count.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt_next;
    end

    // R6
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (cnt == $past(cnt) + {{(CNT_W-1){1'b0}}, 1'b1}));
endmodule

// File: rtl/prd_boundary_track.sv
// Tick boundary tracker. Holds the count at which the next tick falls.
// On a recompute request it loads the first period multiple strictly
// above the updated count; on a tick it advances by one period.
// Assumes the period is a power of two dividing 2^CNT_W.
module prd_boundary_track #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             run,
    input  logic             recalc,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] cnt_next,
    input  logic [CNT_W-1:0] period,
    input  logic [CNT_W-1:0] mask,
    output logic             hit
);
    logic [CNT_W-1:0] target;

    // A tick happens when a strobe brings the count onto the target.
    always_comb hit = run && step && !recalc && (cnt_next == target);

    // Load or advance the next tick point.
    always_ff @(posedge clk) begin
        if (!rst_n)      target <= '0;
        else if (recalc) target <= (cnt_next & mask) + period;
        else if (hit)    target <= target + period;
    end

    // R9
    realign_ahead_chk: assert property (@(posedge clk) disable iff (!rst_n)
        recalc |=> (target != cnt) && ((target - cnt) <= $past(period)));

    // R6
    hit_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> ((cnt_next & ~mask) == '0));
endmodule

// File: rtl/prd_rate_divider.sv
// Periodic interrupt rate divider. Produces the periodic flag pulse and
// the square-wave pulse of a real-time clock from a 32.768 kHz strobe.
// Assumes tick_32k is a one-cycle strobe in the clk domain and that
// cfg_wr accompanies every change of rate_sel, pie_en or sqw_en.
module prd_rate_divider
    import prd_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter bit HAS_SQW = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_32k,
    input  logic [RATE_W-1:0] rate_sel,
    input  logic              pie_en,
    input  logic              sqw_en,
    input  logic              cfg_wr,
    output logic              pf_set,
    output logic              sqw_pulse
);
    logic             active;
    logic [CNT_W-1:0] period;
    logic [CNT_W-1:0] mask;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_next;
    logic             sqw_ok;
    logic             run;
    logic             recalc_q;
    logic             hit;

    generate
        if (HAS_SQW) begin : g_sqw
            // Square-wave output built in: its enable counts.
            always_comb sqw_ok = sqw_en;
        end else begin : g_nosqw
            // No square-wave output: its enable is ignored.
            always_comb sqw_ok = 1'b0;
        end
    endgenerate

    // Divider runs with a nonzero code and an enabled consumer.
    always_comb run = active && (pie_en || sqw_ok);

    prd_rate_decode #(.CNT_W(CNT_W)) decode_i (
        .code   (rate_sel),
        .active (active),
        .period (period),
        .mask   (mask)
    );

    prd_free_counter #(.CNT_W(CNT_W)) counter_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (tick_32k),
        .cnt      (cnt),
        .cnt_next (cnt_next)
    );

    prd_boundary_track #(.CNT_W(CNT_W)) track_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (tick_32k),
        .run      (run),
        .recalc   (recalc_q),
        .cnt      (cnt),
        .cnt_next (cnt_next),
        .period   (period),
        .mask     (mask),
        .hit      (hit)
    );

    // Delay a configuration write by one cycle; recompute once after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) recalc_q <= 1'b1;
        else        recalc_q <= cfg_wr;
    end

    // Register the tick pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pf_set    <= 1'b0;
            sqw_pulse <= 1'b0;
        end else begin
            pf_set    <= hit;
            sqw_pulse <= hit && sqw_ok;
        end
    end

    // R10
    pf_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pf_set |=> !pf_set);

    // R8
    sqw_with_pf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sqw_pulse |-> pf_set);

    // R2
    pf_needs_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pf_set |-> ($past(rate_sel) != '0));

    // R5
    pf_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pf_set |-> ($past(pie_en) || $past(sqw_ok)));
endmodule

// File: tb/prd_rate_divider_tb.sv
// Bench for the periodic rate divider: vector table then directed tests.
module prd_rate_divider_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_32k = 1'b0;
    logic [3:0] rate_sel = 4'd0;
    logic       pie_en = 1'b0;
    logic       sqw_en = 1'b0;
    logic       cfg_wr = 1'b0;
    logic       pf_set;
    logic       sqw_pulse;

    int n_chk = 0;
    int n_fail = 0;
    int tot = 0;
    int pulses, sq, misal, stray, first_at;

    // code, pie, sqw, strobes, expected period (0 = no ticks)
    localparam int VEC [0:6][0:4] = '{
        '{3, 1, 0, 40, 4},
        '{1, 1, 0, 300, 128},
        '{2, 0, 1, 600, 256},
        '{6, 1, 1, 100, 32},
        '{0, 1, 1, 50, 0},
        '{5, 0, 0, 50, 0},
        '{15, 1, 0, 33000, 16384}
    };

    always #2 clk = ~clk;

    prd_rate_divider dut_i (
        .clk(clk), .rst_n(rst_n), .tick_32k(tick_32k), .rate_sel(rate_sel),
        .pie_en(pie_en), .sqw_en(sqw_en), .cfg_wr(cfg_wr),
        .pf_set(pf_set), .sqw_pulse(sqw_pulse)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clk1();
        @(posedge clk);
        #1;
    endtask

    task automatic cfg(input int code, input bit pie, input bit sqw);
        rate_sel = code[3:0];
        pie_en = pie;
        sqw_en = sqw;
        cfg_wr = 1'b1;
        clk1();
        cfg_wr = 1'b0;
        clk1();
        clk1();
    endtask

    // Issue n strobes, one every second clock, and record the outputs.
    task automatic run_n(input int n, input int per);
        pulses = 0; sq = 0; misal = 0; stray = 0; first_at = -1;
        for (int i = 1; i <= n; i++) begin
            tick_32k = 1'b1;
            clk1();
            tick_32k = 1'b0;
            tot++;
            if (pf_set) begin
                pulses++;
                if (first_at < 0) first_at = i;
                if (per > 0 && (tot % per) != 0) misal++;
            end
            if (sqw_pulse) sq++;
            clk1();
            if (pf_set || sqw_pulse) stray++;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        clk1();
        clk1();
        rst_n = 1'b1;
        clk1();
        // R1 reset state
        chk(pf_set == 1'b0, "R1 pf after reset", pf_set, 0);
        chk(sqw_pulse == 1'b0, "R1 sqw after reset", sqw_pulse, 0);
        // R1 counter starts at zero: code 3 ticks after the 4th strobe
        cfg(3, 1, 0);
        run_n(4, 4);
        chk(first_at == 4, "R1 first tick from zero count", first_at, 4);

        foreach (VEC[v]) begin
            int code, pie, sqw, n, per, c0, expp, exps;
            code = VEC[v][0]; pie = VEC[v][1]; sqw = VEC[v][2];
            n = VEC[v][3]; per = VEC[v][4];
            cfg(code, pie[0], sqw[0]);
            c0 = tot;
            run_n(n, per);
            expp = (per > 0) ? ((c0 + n) / per - c0 / per) : 0;
            exps = (sqw != 0) ? expp : 0;
            // R2 R3 R4 R5 tick count for this code/enable set
            chk(pulses == expp, $sformatf("R3/R4/R2/R5 ticks code %0d", code), pulses, expp);
            // R6 alignment, R7 flag without pie
            chk(misal == 0, $sformatf("R6 alignment code %0d", code), misal, 0);
            // R8 square-wave pulses
            chk(sq == exps, $sformatf("R8 sqw count code %0d", code), sq, exps);
            // R10 no pulse outside the cycle after a strobe
            chk(stray == 0, $sformatf("R10 stray pulses code %0d", code), stray, 0);
        end

        // R7: divider run by square-wave enable alone still sets the flag
        cfg(3, 0, 1);
        run_n(8, 4);
        chk(pulses == 2, "R7 flag with pie low", pulses, 2);
        chk(sq == 2, "R8 sqw with pie low", sq, 2);

        // R9: misalign the count, then realign on write
        cfg(0, 0, 0);
        run_n(3, 0);
        begin
            int expf;
            expf = 8 - (tot % 8);
            cfg(4, 1, 0);
            run_n(20, 8);
            chk(first_at == expf, "R9 first tick after write", first_at, expf);
            chk(misal == 0, "R9 realigned ticks", misal, 0);
        end

        // R5: both enables low gives no tick on a fast code
        cfg(3, 0, 0);
        run_n(16, 0);
        chk(pulses == 0, "R5 idle without enables", pulses, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule